// File: doc/BRIEF.md
# OFDM Cyclic Prefix Extender

This block sits after the inverse transform of an OFDM transmitter. It takes one symbol of 64 complex time-domain samples and sends out an extended symbol of 81 samples. The first 16 outputs are a guard prefix copied from the tail of the symbol. The full symbol follows. A single extra copy of the first sample closes the sequence, for windowing across the symbol boundary.

Because the prefix comes from the end of the symbol, nothing can be sent until the whole symbol has arrived. The block therefore holds each symbol in one of two 64-entry banks. While one bank is read out, the next symbol is written into the other. Both sides use valid/ready handshakes. Real and imaginary parts have a configurable width and pass through unchanged.

Top module: `ofdm_guard_extender`

## Requirements
- R1: Every 64 accepted input samples form one symbol, and each symbol produces exactly 81 output transfers.
- R2: Output positions 0 to 15 of a symbol carry input samples 48 to 63, in that order.
- R3: Output positions 16 to 79 carry input samples 0 to 63, in that order.
- R4: Output position 80 carries input sample 0 again.
- R5: `out_last` is 1 at output position 80 and 0 at every other position.
- R6: After reset, `out_valid` is 0 and `in_ready` is 1. `out_valid` stays 0 until sample 63 of a symbol has been accepted, and it is 1 in the cycle after that.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output data, `out_last` and the read position do not change.
- R8: A second symbol can be accepted while the first one is still waiting to be read. `in_ready` is 0 while two complete symbols are waiting.
- R9: The real part (`in_re` to `out_re`) and the imaginary part (`in_im` to `out_im`) are copied bit for bit.
- R10: Symbols leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can accept an input sample |
| in_re | input | DW | Real part of the input sample |
| in_im | input | DW | Imaginary part of the input sample |
| out_valid | output | 1 | Output sample is valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_re | output | DW | Real part of the output sample |
| out_im | output | DW | Imaginary part of the output sample |
| out_last | output | 1 | Marks the final (81st) sample of a symbol |

## Verification
The bench targets the three seams of the output order:
- The step from prefix to body, where an off-by-one would repeat or skip sample 63 or sample 0.
- The trailing copy, where a design that wraps too early would emit sample 1 or drop the copy.
- The position of `out_last`, where an off-by-one would mark the wrong sample.

It holds output ready low while two symbols arrive. A design without a second bank would stall the second symbol. A design that ignores full banks would overwrite a symbol that has not been sent. Random output stalls check that a design advancing the read position on a stall would lose or repeat samples. The bench also checks that no output starts before the symbol's tail has arrived.

// File: rtl/guard_ext_pkg.sv
package guard_ext_pkg;
  // Symbol index read at output position pos: tail first, then body, then the head again.
  function automatic int guard_src_index(input int pos, input int nfft, input int ncp);
    if (pos < ncp)
      return nfft - ncp + pos;
    else if (pos < ncp + nfft)
      return pos - ncp;
    else
      return 0;
  endfunction
endpackage

// File: rtl/guard_fill_ctrl.sv
module guard_fill_ctrl #(
  parameter int NFFT = 64,
  localparam int AW  = $clog2(NFFT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output logic          filled
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(NFFT - 1);

  assign filled = wr_fire && (wr_addr == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_bank <= 1'b0;
    end else if (wr_fire) begin
      if (wr_addr == LAST_ADDR) begin
        wr_addr <= '0;
        wr_bank <= ~wr_bank;
      end else begin
        wr_addr <= wr_addr + 1'b1;
      end
    end
  end

  // R1
  bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filled |=> (wr_addr == '0) && (wr_bank != $past(wr_bank)));
endmodule

// File: rtl/guard_sym_store.sv
module guard_sym_store #(
  parameter int DW   = 16,
  parameter int NFFT = 64,
  localparam int AW  = $clog2(NFFT)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_re,
  input  logic [DW-1:0] wr_im,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_re,
  output logic [DW-1:0] rd_im
);
  logic [2*DW-1:0] bank_word [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [2*DW-1:0] cells [NFFT];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b)))
        cells[wr_addr] <= {wr_re, wr_im};
    end
    assign bank_word[b] = cells[rd_addr];
  end

  assign rd_re = bank_word[rd_bank][2*DW-1:DW];
  assign rd_im = bank_word[rd_bank][DW-1:0];
endmodule

// File: rtl/guard_read_seq.sv
module guard_read_seq
  import guard_ext_pkg::*;
#(
  parameter int NFFT  = 64,
  parameter int NCP   = 16,
  localparam int AW   = $clog2(NFFT),
  localparam int OUTLEN = NCP + NFFT + 1,
  localparam int PW   = $clog2(OUTLEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          at_end,
  output logic          sym_done
);
  localparam logic [PW-1:0] END_POS = PW'(OUTLEN - 1);

  logic [PW-1:0] pos;

  assign rd_addr  = AW'(guard_src_index(int'(pos), NFFT, NCP));
  assign at_end   = (pos == END_POS);
  assign sym_done = advance && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      rd_bank <= 1'b0;
    end else if (advance) begin
      if (at_end) begin
        pos     <= '0;
        rd_bank <= ~rd_bank;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  // R7
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(pos) && $stable(rd_bank));
endmodule

// File: rtl/ofdm_guard_extender.sv
module ofdm_guard_extender #(
  parameter int DW   = 16,
  parameter int NFFT = 64,
  parameter int NCP  = 16,
  localparam int AW  = $clog2(NFFT),
  localparam int OUTLEN = NCP + NFFT + 1,
  localparam int PW  = $clog2(OUTLEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im,
  output logic          out_last
);
  logic [1:0]    full_q;
  logic          wr_fire, wr_bank, filled;
  logic [AW-1:0] wr_addr;
  logic          rd_fire, rd_bank, at_end, sym_done;
  logic [AW-1:0] rd_addr;

  assign in_ready  = !full_q[wr_bank];
  assign wr_fire   = in_valid && in_ready;
  assign out_valid = full_q[rd_bank];
  assign rd_fire   = out_valid && out_ready;
  assign out_last  = out_valid && at_end;

  guard_fill_ctrl #(.NFFT(NFFT)) u_fill (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
    .wr_bank(wr_bank), .wr_addr(wr_addr), .filled(filled)
  );

  guard_sym_store #(.DW(DW), .NFFT(NFFT)) u_store (
    .clk(clk), .wr_en(wr_fire), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_re(in_re), .wr_im(in_im), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .rd_re(out_re), .rd_im(out_im)
  );

  guard_read_seq #(.NFFT(NFFT), .NCP(NCP)) u_read (
    .clk(clk), .rst_n(rst_n), .advance(rd_fire), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .at_end(at_end), .sym_done(sym_done)
  );

  for (genvar b = 0; b < 2; b++) begin : g_full
    always_ff @(posedge clk) begin
      if (!rst_n)
        full_q[b] <= 1'b0;
      else if (filled && (wr_bank == 1'(b)))
        full_q[b] <= 1'b1;
      else if (sym_done && (rd_bank == 1'(b)))
        full_q[b] <= 1'b0;
    end
  end

  // Assertion support: symbols waiting and transfers seen in the current symbol.
  logic [1:0]    pending;
  logic [PW-1:0] seen_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= '0;
      seen_cnt <= '0;
    end else begin
      pending <= pending + {1'b0, filled} - {1'b0, sym_done};
      if (rd_fire) seen_cnt <= out_last ? '0 : seen_cnt + 1'b1;
    end
  end

  // R6
  valid_needs_symbol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pending != 2'd0);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= 2'd2);
  // R8
  full_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == 2'd2) |-> !in_ready);
  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im) && $stable(out_last));
  // R5
  last_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> (out_last == (seen_cnt == PW'(OUTLEN - 1))));
  // R8
  bank_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && out_last |=> !full_q[$past(rd_bank)]);
endmodule

// File: tb/ofdm_guard_extender_test.sv
module ofdm_guard_extender_test;
  localparam int DW = 16;
  localparam int NFFT = 64;
  localparam int NCP = 16;
  localparam int OUTLEN = NFFT + NCP + 1;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid, out_last;
  logic [DW-1:0] out_re, out_im;

  int errors = 0, checks = 0;
  int accepted = 0;
  bit allow_rd = 0;
  int stall_pct = 0;
  logic [2*DW-1:0] exp_q[$];

  always #4 clk = ~clk;

  ofdm_guard_extender #(.DW(DW), .NFFT(NFFT), .NCP(NCP)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Driver: builds a random symbol, queues its extended form, streams it in.
  task automatic send_symbol(input int gap_pct, input bit early_chk);
    logic [2*DW-1:0] sym [NFFT];
    for (int i = 0; i < NFFT; i++) sym[i] = {16'($urandom), 16'($urandom)};
    for (int k = NFFT - NCP; k < NFFT; k++) exp_q.push_back(sym[k]);
    for (int k = 0; k < NFFT; k++) exp_q.push_back(sym[k]);
    exp_q.push_back(sym[0]);
    for (int i = 0; i < NFFT; i++) begin
      @(negedge clk);
      while (($urandom % 100) < gap_pct) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1;
      {in_re, in_im} = sym[i];
      #1;
      if (early_chk) check(out_valid == 0, "R6 early output", 32'(out_valid), 0);
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      accepted++;
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  // Monitor / scoreboard
  initial begin : monitor
    int opos = 0;
    bit was_stalled = 0;
    logic [2*DW-1:0] held = '0;
    bit held_last = 0;
    logic [2*DW-1:0] exp;
    forever begin
      @(negedge clk);
      out_ready = allow_rd && (($urandom % 100) >= stall_pct);
      #1;
      if (rst_n) begin
        if (was_stalled)
          check(out_valid && {out_re, out_im} == held && out_last == held_last,
                "R7 stall hold", {out_re, out_im}, held);
        was_stalled = out_valid && !out_ready;
        held = {out_re, out_im};
        held_last = out_last;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(0, "R1 unexpected output", {out_re, out_im}, 0);
          end else begin
            exp = exp_q.pop_front();
            if (opos < NCP)
              check({out_re, out_im} == exp, "R2 prefix", {out_re, out_im}, exp);
            else if (opos < NCP + NFFT)
              check({out_re, out_im} == exp, "R3 body R9 R10", {out_re, out_im}, exp);
            else
              check({out_re, out_im} == exp, "R4 trailing copy", {out_re, out_im}, exp);
            check(out_last == (opos == OUTLEN - 1), "R5 last flag", 32'(out_last), 32'(opos == OUTLEN - 1));
          end
          opos = (opos + 1) % OUTLEN;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    check(out_valid == 0, "R6 reset out_valid", 32'(out_valid), 0);
    check(in_ready == 1, "R6 reset in_ready", 32'(in_ready), 1);

    // Phase 1: reads held off; first symbol must not appear before its tail.
    send_symbol(0, 1);
    #1;
    check(out_valid == 1, "R6 valid after tail", 32'(out_valid), 1);
    // Second symbol goes into the other bank while the first waits.
    send_symbol(20, 0);
    check(accepted == 2 * NFFT, "R8 second symbol accepted", 32'(accepted), 2 * NFFT);
    in_valid = 1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      #1;
      check(in_ready == 0, "R8 both banks full", 32'(in_ready), 0);
    end
    in_valid = 0;

    // Phase 2: drain with random stalls, more symbols back to back.
    allow_rd = 1;
    stall_pct = 30;
    for (int s = 0; s < 4; s++) send_symbol(s * 10, 0);
    stall_pct = 0;
    send_symbol(0, 0);
    send_symbol(0, 0);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 0, "R1 no extra output", 32'(out_valid), 0);
    check(in_ready == 1, "R8 banks released", 32'(in_ready), 1);
    summary();
    $finish;
  end
endmodule